// File: doc/BRIEF.md
# Banked Register File Decoder

This block is the data-memory front end of a small 8-bit controller core. Each access arrives either as a 7-bit direct field qualified by a single bank-select bit, or as a full 8-bit pointer value for indirect access. The block forms one 8-bit data address from these inputs and classifies it into one of four regions. Two regions are special-function-register space and the on-chip general-purpose RAM. The third is a 16-byte mirror window in the upper bank that reaches the top of the lower bank's RAM. The fourth is unimplemented space.

The block holds the 64-byte RAM itself. Special-function-register traffic is handed to an external register block through a select, a bank flag, a 5-bit offset and a write strobe, and that block returns its read value. RAM writes are committed on the rising clock edge. Every read is combinational from the formed address. Unimplemented locations read as zero and swallow writes. An indirect access whose pointer names the indirect-data register itself is treated the same way.

Top module: `bankreg_decoder`

## Requirements
- R1: With `use_ind` = 0 the formed address on `full_addr` is {`bank_sel`, `dir_addr`}, so `bank_sel` = 0 reaches 00h–7Fh and `bank_sel` = 1 reaches 80h–FFh.
- R2: Offsets 00h–1Fh within either bank give `region` = 2'b00 and `sfr_sel` = 1. `sfr_bank` is then bit 7 of the address and `sfr_ofs` is its low 5 bits. `rd_data` equals `sfr_rdata`, and `sfr_we` equals `wr_en`. Outside this region `sfr_sel` and `sfr_we` are 0.
- R3: Addresses 40h–7Fh give `region` = 2'b01 and select one of 64 distinct 8-bit RAM cells (cell = address − 40h). A write is stored at the rising clock edge, and a read returns the cell combinationally.
- R4: Addresses F0h–FFh give `region` = 2'b10 and reach the same cells as 70h–7Fh. A write through either range is visible through the other.
- R5: Every other address (20h–3Fh, A0h–EFh) gives `region` = 2'b11 and reads 00h. A write there changes no RAM cell and raises no `sfr_we`.
- R6: With `use_ind` = 1 the formed address on `full_addr` is the 8-bit pointer `fsr`.
- R7: With `use_ind` = 1 and a pointer whose low 7 bits are 00h (the indirect-data register, 00h or 80h), `region` = 2'b11, `rd_data` = 00h, `sfr_sel` = 0, and no write occurs.
- R8: While `rst_n` is low, no RAM cell is written and `sfr_we` stays 0. Reset does not clear RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks all writes while low |
| bank_sel | input | 1 | Bank choice for direct access |
| dir_addr | input | 7 | Direct address field |
| use_ind | input | 1 | 1 = address comes from the pointer |
| fsr | input | 8 | Indirect pointer |
| wr_en | input | 1 | Write request for the current access |
| wr_data | input | 8 | Write data (also seen by the register block) |
| rd_data | output | 8 | Read data for the current access |
| full_addr | output | 8 | Formed data address |
| region | output | 2 | 00 register space, 01 RAM, 10 mirror, 11 unimplemented |
| sfr_sel | output | 1 | Access targets register space |
| sfr_bank | output | 1 | Bank of the register access |
| sfr_ofs | output | 5 | Register offset within the bank |
| sfr_we | output | 1 | Write strobe to the register block |
| sfr_rdata | input | 8 | Read value from the register block |

## Verification
Two functions can meet in one cycle. A write through the mirror window and a read of its lower-bank twin touch one storage cell. A write request can also land on an address that must be ignored while earlier RAM contents must survive. The bench writes through F0h–FFh and immediately reads 70h–7Fh, and the reverse. It then fires write strobes at unimplemented addresses, at self-referencing pointers and under reset. Each of these is judged by reading back every affected RAM cell against a model kept in the bench.

// File: rtl/brf_pkg.sv
`timescale 1ns/1ps
package brf_pkg;
   typedef enum logic [1:0] {
      RG_SFR   = 2'b00,
      RG_RAM   = 2'b01,
      RG_ALIAS = 2'b10,
      RG_NONE  = 2'b11
   } region_e;
endpackage

// File: rtl/brf_addr_mux.sv
`timescale 1ns/1ps
module brf_addr_mux #(
   parameter int DIR_W  = 7,
   parameter int ADDR_W = 8
) (
   input  logic              bank_sel,
   input  logic [DIR_W-1:0]  dir_addr,
   input  logic              use_ind,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] addr
);
   if (ADDR_W != DIR_W + 1) begin : g_bad_width
      $error("brf_addr_mux: ADDR_W must be DIR_W + 1");
   end

   logic [ADDR_W-1:0] direct_addr;
   assign direct_addr = {bank_sel, dir_addr};
   assign addr        = use_ind ? ptr : direct_addr;
endmodule

// File: rtl/brf_decode.sv
`timescale 1ns/1ps
module brf_decode
   import brf_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int SFR_SPAN     = 32,
   parameter int RAM_BASE     = 'h40,
   parameter int RAM_DEPTH    = 64,
   parameter bit ALIAS_EN     = 1'b1,
   parameter int ALIAS_BASE   = 'hF0,
   parameter int ALIAS_LEN    = 16,
   parameter int ALIAS_TARGET = 'h70,
   parameter int IND_OFS      = 0,
   localparam int IDX_W       = $clog2(RAM_DEPTH),
   localparam int SFR_W       = $clog2(SFR_SPAN)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              use_ind,
   output region_e           region,
   output logic [IDX_W-1:0]  ram_idx,
   output logic [SFR_W-1:0]  sfr_ofs
);
   localparam int OFS_W = ADDR_W - 1;
   localparam int EXT_W = ADDR_W + 1;
   localparam logic [EXT_W-1:0] SFR_END = EXT_W'(SFR_SPAN);
   localparam logic [EXT_W-1:0] RAM_LO  = EXT_W'(RAM_BASE);
   localparam logic [EXT_W-1:0] RAM_HI  = EXT_W'(RAM_BASE + RAM_DEPTH);
   localparam logic [EXT_W-1:0] AL_LO   = EXT_W'(ALIAS_BASE);
   localparam logic [EXT_W-1:0] AL_HI   = EXT_W'(ALIAS_BASE + ALIAS_LEN);
   localparam logic [EXT_W-1:0] AL_SHIFT = EXT_W'(ALIAS_TARGET - RAM_BASE);
   localparam logic [EXT_W-1:0] IND_EXT = EXT_W'(IND_OFS);

   if (RAM_DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("brf_decode: RAM_DEPTH must be a power of two");
   end
   if (SFR_SPAN > RAM_BASE) begin : g_bad_sfr
      $error("brf_decode: register space overlaps RAM");
   end
   if (IND_OFS >= SFR_SPAN) begin : g_bad_ind
      $error("brf_decode: indirect register outside register space");
   end
   if (RAM_BASE + RAM_DEPTH > (1 << OFS_W)) begin : g_bad_ram
      $error("brf_decode: RAM must lie in the lower bank");
   end
   if (ALIAS_EN && (ALIAS_TARGET < RAM_BASE ||
                    ALIAS_TARGET + ALIAS_LEN > RAM_BASE + RAM_DEPTH)) begin : g_bad_alias
      $error("brf_decode: mirror target outside RAM");
   end

   logic                 bank;
   logic [EXT_W-1:0]     ext_addr;
   logic [EXT_W-1:0]     ext_ofs;
   logic                 self_ref;
   logic                 sfr_hit;
   logic                 ram_hit;
   logic                 alias_hit;
   logic [EXT_W-1:0]     ram_lin;
   logic [EXT_W-1:0]     alias_lin;

   assign bank     = addr[ADDR_W-1];
   assign ext_addr = {1'b0, addr};
   assign ext_ofs  = {2'b00, addr[OFS_W-1:0]};
   assign self_ref = use_ind && (ext_ofs == IND_EXT);
   assign sfr_hit  = ext_ofs < SFR_END;
   assign ram_hit  = !bank && (ext_addr >= RAM_LO) && (ext_addr < RAM_HI);
   assign ram_lin  = ext_addr - RAM_LO;

   if (ALIAS_EN) begin : g_alias
      assign alias_hit = (ext_addr >= AL_LO) && (ext_addr < AL_HI);
      assign alias_lin = ext_addr - AL_LO + AL_SHIFT;
   end else begin : g_no_alias
      assign alias_hit = 1'b0;
      assign alias_lin = '0;
   end

   always_comb begin
      region  = RG_NONE;
      ram_idx = '0;
      if (self_ref) begin
         region = RG_NONE;
      end else if (sfr_hit) begin
         region = RG_SFR;
      end else if (ram_hit) begin
         region  = RG_RAM;
         ram_idx = ram_lin[IDX_W-1:0];
      end else if (alias_hit) begin
         region  = RG_ALIAS;
         ram_idx = alias_lin[IDX_W-1:0];
      end
   end

   assign sfr_ofs = addr[SFR_W-1:0];
endmodule

// File: rtl/brf_ram.sv
`timescale 1ns/1ps
module brf_ram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[idx] <= wdata;
      end
   end

   assign rdata = cells[idx];
endmodule

// File: rtl/bankreg_decoder.sv
`timescale 1ns/1ps
module bankreg_decoder
   import brf_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int DIR_W        = 7,
   parameter int SFR_SPAN     = 32,
   parameter int RAM_BASE     = 'h40,
   parameter int RAM_DEPTH    = 64,
   parameter bit ALIAS_EN     = 1'b1,
   parameter int ALIAS_BASE   = 'hF0,
   parameter int ALIAS_LEN    = 16,
   parameter int ALIAS_TARGET = 'h70,
   parameter int IND_OFS      = 0,
   localparam int ADDR_W      = DIR_W + 1,
   localparam int SFR_W       = $clog2(SFR_SPAN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_sel,
   input  logic [DIR_W-1:0]  dir_addr,
   input  logic              use_ind,
   input  logic [ADDR_W-1:0] fsr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] full_addr,
   output logic [1:0]        region,
   output logic              sfr_sel,
   output logic              sfr_bank,
   output logic [SFR_W-1:0]  sfr_ofs,
   output logic              sfr_we,
   input  logic [DATA_W-1:0] sfr_rdata
);
   localparam int IDX_W = $clog2(RAM_DEPTH);

   region_e             rg;
   logic [IDX_W-1:0]    ram_idx;
   logic [DATA_W-1:0]   ram_q;
   logic                ram_we;
   logic                wr_ok;

   brf_addr_mux #(
      .DIR_W  (DIR_W),
      .ADDR_W (ADDR_W)
   ) u_mux (
      .bank_sel (bank_sel),
      .dir_addr (dir_addr),
      .use_ind  (use_ind),
      .ptr      (fsr),
      .addr     (full_addr)
   );

   brf_decode #(
      .ADDR_W       (ADDR_W),
      .SFR_SPAN     (SFR_SPAN),
      .RAM_BASE     (RAM_BASE),
      .RAM_DEPTH    (RAM_DEPTH),
      .ALIAS_EN     (ALIAS_EN),
      .ALIAS_BASE   (ALIAS_BASE),
      .ALIAS_LEN    (ALIAS_LEN),
      .ALIAS_TARGET (ALIAS_TARGET),
      .IND_OFS      (IND_OFS)
   ) u_dec (
      .addr    (full_addr),
      .use_ind (use_ind),
      .region  (rg),
      .ram_idx (ram_idx),
      .sfr_ofs (sfr_ofs)
   );

   assign wr_ok  = wr_en && rst_n;
   assign ram_we = wr_ok && ((rg == RG_RAM) || (rg == RG_ALIAS));

   brf_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (RAM_DEPTH)
   ) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .idx   (ram_idx),
      .wdata (wr_data),
      .rdata (ram_q)
   );

   assign region   = rg;
   assign sfr_sel  = (rg == RG_SFR);
   assign sfr_bank = full_addr[ADDR_W-1];
   assign sfr_we   = wr_ok && sfr_sel;

   always_comb begin
      unique case (rg)
         RG_SFR:   rd_data = sfr_rdata;
         RG_RAM:   rd_data = ram_q;
         RG_ALIAS: rd_data = ram_q;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/brf_checker.sv
`timescale 1ns/1ps
module brf_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic       use_ind,
   input logic [7:0] fsr,
   input logic [7:0] full_addr,
   input logic [7:0] wr_data,
   input logic [7:0] rd_data,
   input logic [7:0] sfr_rdata,
   input logic [1:0] region,
   input logic       sfr_sel,
   input logic       sfr_we
);
   AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      region == 2'b11 |-> rd_data == 8'h00);                        // R5
   AST_SFR_READ: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_sel |-> rd_data == sfr_rdata);                            // R2
   AST_SFR_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      sfr_we |-> (wr_en && region == 2'b00));                       // R2
   AST_IND_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      use_ind |-> full_addr == fsr);                                // R6
   AST_SELF_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ind && fsr[6:0] == 7'h00) |-> (region == 2'b11 && !sfr_we)); // R7
   AST_RAM_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (region == 2'b01 || region == 2'b10))
         |=> (!$stable(full_addr) || rd_data == $past(wr_data)));   // R3
   AST_RESET_NO_WRITE: assert property (@(posedge clk)
      !rst_n |-> !sfr_we);                                          // R8
endmodule

bind bankreg_decoder brf_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .use_ind   (use_ind),
   .fsr       (fsr),
   .full_addr (full_addr),
   .wr_data   (wr_data),
   .rd_data   (rd_data),
   .sfr_rdata (sfr_rdata),
   .region    (region),
   .sfr_sel   (sfr_sel),
   .sfr_we    (sfr_we)
);

// File: tb/tb_bankreg_decoder.sv
`timescale 1ns/1ps
module tb_bankreg_decoder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       bank_sel;
   logic [6:0] dir_addr;
   logic       use_ind;
   logic [7:0] fsr;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic [7:0] full_addr;
   logic [1:0] region;
   logic       sfr_sel;
   logic       sfr_bank;
   logic [4:0] sfr_ofs;
   logic       sfr_we;
   logic [7:0] sfr_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [7:0] model [64];

   always #2.5 clk = ~clk;

   bankreg_decoder dut (
      .clk, .rst_n, .bank_sel, .dir_addr, .use_ind, .fsr, .wr_en, .wr_data,
      .rd_data, .full_addr, .region, .sfr_sel, .sfr_bank, .sfr_ofs, .sfr_we,
      .sfr_rdata
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int cell_of(logic [7:0] a);
      if (a >= 8'h40 && a <= 8'h7F) return int'(a) - 'h40;
      return int'(a) - 'hC0;
   endfunction

   task automatic drive(bit ind, logic [7:0] a);
      use_ind = ind;
      fsr = ind ? a : 8'h00;
      bank_sel = ind ? 1'b0 : a[7];
      dir_addr = ind ? 7'h00 : a[6:0];
   endtask

   task automatic acc_write(bit ind, logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      drive(ind, a);
      wr_data = d;
      wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic acc_read(bit ind, logic [7:0] a);
      @(negedge clk);
      drive(ind, a);
      wr_en = 1'b0;
      #1;
   endtask

   task automatic t_direct_form;
      acc_read(1'b0, 8'h45);
      chk("R1 full_addr bank0", full_addr, 8'h45);
      chk("R3 region ram", region, 2'b01);
      acc_read(1'b0, 8'h85);
      chk("R1 full_addr bank1", full_addr, 8'h85);
      chk("R2 region sfr bank1", region, 2'b00);
      chk("R2 sfr_bank", sfr_bank, 1'b1);
      chk("R2 sfr_ofs", sfr_ofs, 5'h05);
   endtask

   task automatic t_sfr_port;
      sfr_rdata = 8'h9A;
      acc_read(1'b0, 8'h1F);
      chk("R2 sfr read", rd_data, 8'h9A);
      chk("R2 sfr_sel", sfr_sel, 1'b1);
      chk("R2 sfr_ofs top", sfr_ofs, 5'h1F);
      @(negedge clk);
      drive(1'b0, 8'h9F);
      wr_en = 1'b1;
      #1 chk("R2 sfr_we follows wr_en", sfr_we, 1'b1);
      chk("R2 sfr_bank high", sfr_bank, 1'b1);
      drive(1'b0, 8'h45);
      #1 chk("R2 no sfr_we for ram", sfr_we, 1'b0);
      chk("R2 no sfr_sel for ram", sfr_sel, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_ram_fill;
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
         model[i] = 8'(i * 7 + 3);
         acc_write(1'b0, 8'(8'h40 + i), model[i]);
      end
      for (int i = 0; i < 64; i++) begin
         acc_read(1'b0, 8'(8'h40 + i));
         if (rd_data !== model[i]) bad++;
      end
      chk("R3 all 64 cells distinct readback", bad, 0);
   endtask

   task automatic t_alias;
      acc_write(1'b0, 8'hF3, 8'hC4);
      model[cell_of(8'hF3)] = 8'hC4;
      acc_read(1'b0, 8'h73);
      chk("R4 mirror write seen at 73h", rd_data, 8'hC4);
      acc_write(1'b0, 8'h7F, 8'h5E);
      model[cell_of(8'h7F)] = 8'h5E;
      acc_read(1'b0, 8'hFF);
      chk("R4 7Fh write seen at FFh", rd_data, 8'h5E);
      chk("R4 region mirror", region, 2'b10);
      acc_read(1'b0, 8'hF0);
      chk("R4 F0h maps to 70h", rd_data, model[cell_of(8'h70)]);
   endtask

   task automatic t_unimpl;
      logic [7:0] holes [5] = '{8'h20, 8'h3F, 8'hA0, 8'hC5, 8'hEF};
      int bad = 0;
      sfr_rdata = 8'h66;
      foreach (holes[k]) begin
         acc_read(1'b0, holes[k]);
         chk("R5 hole region", region, 2'b11);
         chk("R5 hole reads zero", rd_data, 8'h00);
         @(negedge clk);
         wr_data = 8'hFF;
         wr_en = 1'b1;
         #1 chk("R5 hole no sfr_we", sfr_we, 1'b0);
         @(posedge clk);
         #1 wr_en = 1'b0;
      end
      for (int i = 0; i < 64; i++) begin
         acc_read(1'b0, 8'(8'h40 + i));
         if (rd_data !== model[i]) bad++;
      end
      chk("R5 ram untouched by hole writes", bad, 0);
   endtask

   task automatic t_indirect;
      acc_read(1'b1, 8'h4A);
      chk("R6 ptr forms address", full_addr, 8'h4A);
      chk("R6 ptr reads ram", rd_data, model[cell_of(8'h4A)]);
      acc_write(1'b1, 8'hF1, 8'h81);
      model[cell_of(8'hF1)] = 8'h81;
      acc_read(1'b0, 8'h71);
      chk("R6 ptr write via mirror", rd_data, 8'h81);
   endtask

   task automatic t_selfref;
      int bad = 0;
      sfr_rdata = 8'hB7;
      for (int b = 0; b < 2; b++) begin
         acc_read(1'b1, b[0] ? 8'h80 : 8'h00);
         chk("R7 self region", region, 2'b11);
         chk("R7 self reads zero", rd_data, 8'h00);
         chk("R7 self no sfr_sel", sfr_sel, 1'b0);
         @(negedge clk);
         wr_data = 8'h11;
         wr_en = 1'b1;
         #1 chk("R7 self no sfr_we", sfr_we, 1'b0);
         @(posedge clk);
         #1 wr_en = 1'b0;
      end
      acc_read(1'b0, 8'h00);
      chk("R2 direct 00h is register space", rd_data, 8'hB7);
      for (int i = 0; i < 64; i++) begin
         acc_read(1'b0, 8'(8'h40 + i));
         if (rd_data !== model[i]) bad++;
      end
      chk("R7 ram untouched by self writes", bad, 0);
   endtask

   task automatic t_reset_hold;
      @(negedge clk);
      rst_n = 1'b0;
      drive(1'b0, 8'h05);
      wr_data = 8'h77;
      wr_en = 1'b1;
      #1 chk("R8 no sfr_we in reset", sfr_we, 1'b0);
      drive(1'b0, 8'h40);
      @(posedge clk);
      #1 drive(1'b0, 8'hF8);
      @(posedge clk);
      #1 wr_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      acc_read(1'b0, 8'h40);
      chk("R8 ram kept, reset write blocked", rd_data, model[0]);
      acc_read(1'b0, 8'h78);
      chk("R8 mirror reset write blocked", rd_data, model[cell_of(8'h78)]);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      rst_n = 1'b0;
      wr_en = 1'b0;
      wr_data = 8'h00;
      sfr_rdata = 8'h00;
      drive(1'b0, 8'h05);
      wr_en = 1'b1;
      #1 chk("R8 reset state sfr_we low", sfr_we, 1'b0);
      wr_en = 1'b0;
      drive(1'b0, 8'h30);
      #1 chk("R5 reset state hole reads zero", rd_data, 8'h00);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_direct_form();
      t_sfr_port();
      t_ram_fill();
      t_alias();
      t_unimpl();
      t_indirect();
      t_selfref();
      t_reset_hold();
      finish_run();
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      finish_run();
   end
endmodule